// File: doc/BRIEF.md
# Offload Command Replay Sequencer

This block plays back a short program of bus commands with no software in the loop. Software first fills two small word-addressed stores through a simple write port: a command store that holds the command words, and a payload store that holds the bytes for the write commands. It then sets the run mode to offload, programs how many commands make up one burst, and pulses a trigger. The sequencer hands each stored command to the bus engine over a valid/ready channel. For every write command it then streams that command's payload bytes over a second valid/ready channel.

Each write command with a non-zero length starts reading at a fresh payload word. It takes its bytes lowest lane first and runs into the following words when its length exceeds one word. Read commands and zero-length writes take no payload word. When the last command of the burst has been accepted and its payload sent, both pointers rewind to entry 0. A one-cycle completion pulse is raised and the block waits for the next trigger.

Top module: `offload_replay`

## Requirements
- R1: While `cfg_offload` is 0 (direct mode), a trigger is ignored. The block stays idle and drives no command.
- R2: A burst count of 0 makes a trigger do nothing. `busy` stays low and no command is issued.
- R3: A trigger taken while idle, with offload mode and a non-zero count N, raises `busy`. `cmd_valid` rises in the next cycle. Stored commands 0 to N-1 are then presented in index order, each exactly as stored.
- R4: While `cmd_valid` or `sdo_valid` is high and its ready is low, the valid stays high and the presented word or byte holds steady.
- R5: Command word fields: bit 0 is 1 for a read, and bits [19:8] are the payload byte count. A write with count L delivers exactly L bytes after its command is accepted and before the next command, lowest lane (bits [7:0]) first.
- R6: Each write with L > 0 starts at the next unused payload word and uses ceil(L/4) consecutive words. Reads and zero-length writes use none. The first write of a burst starts at word 0.
- R7: `done` is a single-cycle pulse in the cycle after the final handshake of the burst (the last command, or its last payload byte). `busy` is low in that same cycle.
- R8: Every new burst restarts at command entry 0 and payload word 0.
- R9: A trigger that arrives while a burst is running has no effect on that burst.
- R10: A write-port cycle with `mem_sel` = 0 stores `mem_data` into command entry `mem_addr`. With `mem_sel` = 1 it stores into payload word `mem_addr`, taking effect at the next clock.
- R11: After reset the block is idle: `busy`, `done`, `cmd_valid` and `sdo_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_offload | input | 1 | Run mode: 0 direct, 1 offload |
| cfg_count | input | 4 | Commands per burst |
| mem_wr_en | input | 1 | Store write strobe |
| mem_sel | input | 1 | Store select: 0 command, 1 payload |
| mem_addr | input | 4 | Entry index |
| mem_data | input | 32 | Word to store |
| trigger | input | 1 | Single-cycle burst start |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_word | output | 32 | Stored command word |
| sdo_valid | output | 1 | Payload byte presented |
| sdo_ready | input | 1 | Engine accepts byte |
| sdo_byte | output | 8 | Payload byte |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst completion pulse |

## Verification
A trigger sampled at one edge makes `busy` and `cmd_valid` visible one cycle later. Each handshake moves the presented item on from the following cycle, and `done` appears exactly one cycle after the final handshake. The bench expands each accepted trigger into an ordered queue of expected commands and bytes. At every falling edge it compares the valid flags, the presented value, `busy` and `done` with the queue head, which is a register-accurate expectation of what the design drives in that cycle. Ready is stalled pseudo-randomly, so the hold behaviour is checked across many waiting cycles.

// File: rtl/offload_pkg.sv
package offload_pkg;

    // Command word field positions decoded by the sequencer.
    localparam int CMD_RNW_BIT = 0;
    localparam int CMD_LEN_LSB = 8;
    localparam int CMD_LEN_W   = 12;

    // Write-port store select encodings.
    localparam logic MEM_SEL_CMD  = 1'b0;
    localparam logic MEM_SEL_DATA = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

endpackage

// File: rtl/offload_regfile.sv
module offload_regfile #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/offload_byte_pick.sv
module offload_byte_pick #(
    parameter int WORD_W  = 32,
    localparam int LANES  = WORD_W / 8,
    localparam int BSW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [BSW-1:0]    lane_sel,
    output logic [7:0]        byte_out
);

    logic [7:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*8 +: 8];
    end

    assign byte_out = lanes[lane_sel];

endmodule

// File: rtl/offload_seq.sv
module offload_seq
    import offload_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 4,
    parameter int LEN_W  = 12,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LANES = WORD_W / 8,
    localparam int BSW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trigger,
    input  logic             mode_offload,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cmd_ready,
    input  logic             cmd_is_read,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             sdo_ready,
    output logic [AW-1:0]    cmd_idx,
    output logic [AW-1:0]    dat_idx,
    output logic [BSW-1:0]   byte_sel,
    output logic             cmd_valid,
    output logic             sdo_valid,
    output logic             busy,
    output logic             done
);

    localparam logic [BSW-1:0] LANE_LAST = BSW'(LANES - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] idx;
        logic [AW-1:0]    dptr;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] rem;
        logic [BSW-1:0]   bsel;
        logic             done;
    } seq_reg_t;

    seq_reg_t q, d;
    logic     last_cmd;

    assign last_cmd = (q.idx == q.cnt - CNT_W'(1));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (trigger && mode_offload && (cfg_count != '0)) begin
                    d.st   = ST_CMD;
                    d.idx  = '0;
                    d.dptr = '0;
                    d.cnt  = cfg_count;
                end
            end
            ST_CMD: begin
                if (cmd_ready) begin
                    if (!cmd_is_read && (cmd_len != '0)) begin
                        d.st   = ST_DATA;
                        d.rem  = cmd_len;
                        d.bsel = '0;
                    end else if (last_cmd) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.idx  = '0;
                        d.dptr = '0;
                    end else begin
                        d.idx = q.idx + CNT_W'(1);
                    end
                end
            end
            ST_DATA: begin
                if (sdo_ready) begin
                    d.rem = q.rem - LEN_W'(1);
                    if ((q.bsel == LANE_LAST) || (q.rem == LEN_W'(1))) begin
                        d.dptr = q.dptr + AW'(1);
                        d.bsel = '0;
                    end else begin
                        d.bsel = q.bsel + BSW'(1);
                    end
                    if (q.rem == LEN_W'(1)) begin
                        if (last_cmd) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            d.idx  = '0;
                            d.dptr = '0;
                        end else begin
                            d.st  = ST_CMD;
                            d.idx = q.idx + CNT_W'(1);
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cmd_idx   = AW'(q.idx);
    assign dat_idx   = q.dptr;
    assign byte_sel  = q.bsel;
    assign cmd_valid = (q.st == ST_CMD);
    assign sdo_valid = (q.st == ST_DATA);
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;

endmodule

// File: rtl/offload_replay.sv
module offload_replay
    import offload_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int LANES = WORD_W / 8,
    localparam int BSW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_offload,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              mem_wr_en,
    input  logic              mem_sel,
    input  logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_data,
    input  logic              trigger,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [WORD_W-1:0] cmd_word,
    output logic              sdo_valid,
    input  logic              sdo_ready,
    output logic [7:0]        sdo_byte,
    output logic              busy,
    output logic              done
);

    logic [AW-1:0]     cmd_idx;
    logic [AW-1:0]     dat_idx;
    logic [BSW-1:0]    byte_sel;
    logic [WORD_W-1:0] dat_word;
    logic              cmd_we;
    logic              dat_we;

    assign cmd_we = mem_wr_en && (mem_sel == MEM_SEL_CMD);
    assign dat_we = mem_wr_en && (mem_sel == MEM_SEL_DATA);

    offload_regfile #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_cmd_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_we),
        .wr_addr (mem_addr),
        .wr_data (mem_data),
        .rd_addr (cmd_idx),
        .rd_data (cmd_word)
    );

    offload_regfile #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_dat_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dat_we),
        .wr_addr (mem_addr),
        .wr_data (mem_data),
        .rd_addr (dat_idx),
        .rd_data (dat_word)
    );

    offload_byte_pick #(.WORD_W(WORD_W)) u_pick (
        .word     (dat_word),
        .lane_sel (byte_sel),
        .byte_out (sdo_byte)
    );

    offload_seq #(
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W),
        .LEN_W  (CMD_LEN_W),
        .WORD_W (WORD_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .trigger      (trigger),
        .mode_offload (cfg_offload),
        .cfg_count    (cfg_count),
        .cmd_ready    (cmd_ready),
        .cmd_is_read  (cmd_word[CMD_RNW_BIT]),
        .cmd_len      (cmd_word[CMD_LEN_LSB +: CMD_LEN_W]),
        .sdo_ready    (sdo_ready),
        .cmd_idx      (cmd_idx),
        .dat_idx      (dat_idx),
        .byte_sel     (byte_sel),
        .cmd_valid    (cmd_valid),
        .sdo_valid    (sdo_valid),
        .busy         (busy),
        .done         (done)
    );

endmodule

// File: rtl/offload_replay_chk.sv
module offload_replay_chk #(
    parameter int CNT_W  = 4,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_offload,
    input logic [CNT_W-1:0]  cfg_count,
    input logic              trigger,
    input logic              mem_wr_en,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [WORD_W-1:0] cmd_word,
    input logic              sdo_valid,
    input logic              sdo_ready,
    input logic [7:0]        sdo_byte,
    input logic              busy,
    input logic              done
);

    p_direct_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trigger && !cfg_offload) |=> !busy);

    p_zero_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trigger && (cfg_count == '0)) |=> (!busy && !cmd_valid));

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trigger && cfg_offload && (cfg_count != '0)) |=> (busy && cmd_valid));

    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !mem_wr_en) |=> (cmd_valid && $stable(cmd_word)));

    p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_valid && !sdo_ready && !mem_wr_en) |=> (sdo_valid && $stable(sdo_byte)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cmd_valid && !sdo_valid));

    p_done_after_xfer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(cmd_valid || sdo_valid));

endmodule

bind offload_replay offload_replay_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_offload (cfg_offload),
    .cfg_count   (cfg_count),
    .trigger     (trigger),
    .mem_wr_en   (mem_wr_en),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_word    (cmd_word),
    .sdo_valid   (sdo_valid),
    .sdo_ready   (sdo_ready),
    .sdo_byte    (sdo_byte),
    .busy        (busy),
    .done        (done)
);

// File: tb/offload_replay_bench.sv
`timescale 1ns/1ps
module offload_replay_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_offload = 1'b0;
    logic [3:0]  cfg_count = '0;
    logic        mem_wr_en = 1'b0;
    logic        mem_sel = 1'b0;
    logic [3:0]  mem_addr = '0;
    logic [31:0] mem_data = '0;
    logic        trigger = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_word;
    logic        sdo_valid;
    logic        sdo_ready = 1'b1;
    logic [7:0]  sdo_byte;
    logic        busy;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit stall_en = 1'b0;
    bit finished = 1'b0;

    logic [31:0] m_cmd [16];
    logic [31:0] m_dat [16];
    logic [32:0] exp_q [$];
    bit          exp_done = 1'b0;

    offload_replay u_offload_replay (
        .clk(clk), .rst_n(rst_n), .cfg_offload(cfg_offload), .cfg_count(cfg_count),
        .mem_wr_en(mem_wr_en), .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_data(mem_data),
        .trigger(trigger), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
        .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_byte(sdo_byte),
        .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input bit rnw, input logic [6:0] da, input int len,
                                       input bit sr, input bit ccc);
        logic [11:0] l;
        l = 12'(len);
        return {9'b0, ccc, 1'b0, sr, l, da, rnw};
    endfunction

    // Expand a burst of n commands into the ordered expected items.
    task automatic load_burst(input int n);
        int ptr;
        ptr = 0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            int len;
            w = m_cmd[i];
            exp_q.push_back({1'b0, w});
            len = int'(w[19:8]);
            if (!w[0]) begin
                for (int b = 0; b < len; b++) begin
                    logic [31:0] dw;
                    dw = m_dat[(ptr + b / 4) % 16];
                    exp_q.push_back({1'b1, 24'b0, dw[8*(b%4) +: 8]});
                end
                ptr += (len + 3) / 4;
            end
        end
    endtask

    // Cycle reference: compare outputs with queue head at every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit active;
            bit hs;
            active = (exp_q.size() != 0);
            chk(busy == active, "R3/R7", "busy", 64'(busy), 64'(active));
            chk(done == exp_done, "R7", "done", 64'(done), 64'(exp_done));
            if (active) begin
                if (!exp_q[0][32]) begin
                    chk(cmd_valid && !sdo_valid, "R3/R5", "cmd_valid", 64'(cmd_valid), 64'd1);
                    chk(cmd_word == exp_q[0][31:0], "R3/R4/R10", "cmd_word",
                        64'(cmd_word), 64'(exp_q[0][31:0]));
                end else begin
                    chk(sdo_valid && !cmd_valid, "R5", "sdo_valid", 64'(sdo_valid), 64'd1);
                    chk(sdo_byte == exp_q[0][7:0], "R5/R6/R4", "sdo_byte",
                        64'(sdo_byte), 64'(exp_q[0][7:0]));
                end
            end else begin
                chk(!cmd_valid && !sdo_valid, "R1/R2", "valid while idle",
                    64'({cmd_valid, sdo_valid}), 64'd0);
            end
            hs = (cmd_valid && cmd_ready) || (sdo_valid && sdo_ready);
            exp_done = 1'b0;
            if (active && hs) begin
                void'(exp_q.pop_front());
                exp_done = (exp_q.size() == 0);
            end
            if (!active && trigger && cfg_offload && (cfg_count != 0)) begin
                load_burst(int'(cfg_count));
            end
        end
    end

    always @(posedge clk) begin
        #2;
        cmd_ready = stall_en ? (($urandom % 3) != 0) : 1'b1;
        sdo_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr_mem(input bit sel, input int addr, input logic [31:0] val);
        @(posedge clk); #2;
        mem_wr_en = 1'b1; mem_sel = sel; mem_addr = 4'(addr); mem_data = val;
        if (sel) m_dat[addr] = val; else m_cmd[addr] = val;
        @(posedge clk); #2;
        mem_wr_en = 1'b0;
    endtask

    task automatic pulse_trigger();
        @(posedge clk); #2;
        trigger = 1'b1;
        @(posedge clk); #2;
        trigger = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_cmd[i] = '0;
            m_dat[i] = '0;
        end
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R11: idle after reset
        chk(!busy && !done && !cmd_valid && !sdo_valid, "R11", "reset state",
            64'({busy, done, cmd_valid, sdo_valid}), 64'd0);

        // R10: program both stores through the write port
        wr_mem(1'b0, 0, mk(1'b0, 7'h12, 3, 1'b1, 1'b0));
        wr_mem(1'b0, 1, mk(1'b0, 7'h12, 2, 1'b0, 1'b0));
        wr_mem(1'b0, 2, mk(1'b1, 7'h33, 4, 1'b0, 1'b0));
        wr_mem(1'b0, 3, mk(1'b0, 7'h44, 9, 1'b1, 1'b0));
        wr_mem(1'b0, 4, mk(1'b0, 7'h45, 0, 1'b0, 1'b0));
        wr_mem(1'b0, 5, mk(1'b0, 7'h46, 1, 1'b0, 1'b1));
        for (int i = 0; i < 16; i++) begin
            wr_mem(1'b1, i, 32'h10203040 + 32'(i) * 32'h01010101);
        end

        // R1: direct mode ignores trigger
        cfg_offload = 1'b0; cfg_count = 4'd6;
        pulse_trigger();
        @(negedge clk);
        chk(!busy && !cmd_valid, "R1", "trigger in direct mode", 64'(busy), 64'd0);

        // R2: zero count ignores trigger
        cfg_offload = 1'b1; cfg_count = 4'd0;
        pulse_trigger();
        @(negedge clk);
        chk(!busy && !cmd_valid, "R2", "trigger with zero count", 64'(busy), 64'd0);

        // R5/R6: write of 3 then write of 2, no stalls
        cfg_count = 4'd2;
        pulse_trigger();
        @(negedge clk);
        chk(cmd_word == m_cmd[0], "R3", "first command", 64'(cmd_word), 64'(m_cmd[0]));
        wait_idle();

        // R6/R9: full program with stalls, extra trigger mid-burst
        stall_en = 1'b1;
        cfg_count = 4'd6;
        pulse_trigger();
        repeat (5) @(posedge clk);
        pulse_trigger();
        wait_idle();

        // R8: rewind, same burst again starts at entry 0
        pulse_trigger();
        @(negedge clk);
        chk(cmd_word == m_cmd[0], "R8", "restart at entry 0", 64'(cmd_word), 64'(m_cmd[0]));
        wait_idle();

        // Longest burst: fill remaining entries, mixed reads and writes
        for (int i = 6; i < 16; i++) begin
            wr_mem(1'b0, i, mk(1'(i % 3 == 0), 7'(i), (i * 5) % 7, 1'(i % 2), 1'b0));
        end
        cfg_count = 4'd15;
        pulse_trigger();
        wait_idle();
        stall_en = 1'b0;
        cfg_count = 4'd1;
        pulse_trigger();
        wait_idle();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule